// File: doc/BRIEF.md
# Looping Pattern Memory Playback Sequencer

This block plays a stored stimulus pattern out of an external synchronous SRAM into a modulator's parallel sample input. Both run on the data clock. Each stored word is 18 bits wide. The low 16 bits are the I or Q sample. The upper two bits are side signals: bit 16 is the data strobe and bit 17 is the transmit enable. Each word therefore carries its own framing.

While idle, the sequencer parks the SRAM address on the programmed start location. Because of this, the one-cycle read latency of the SRAM is already covered when playback is enabled: the first word presented is the word at the start address, and no stale word goes out. While running, the address advances by one location per clock up to the top of memory. From there it jumps straight back to the start address with no gap cycle, so the pattern repeats for as long as playback stays enabled. A start address written during playback is first used at the next wrap.

A source selector decides what the sample bus carries:
- the pattern memory;
- constant zeros;
- nothing (output enable dropped), so an external generator can drive the bus.

Disabling playback forces the bus to zeros and the side signals low.

Top module: `pattern_playback_seq`

## Requirements
- R1: Synchronous active-high reset drives `sram_addr` to 0, `data_out` to 0, `strobe_out` and `txen_out` low and `data_oe` low.
- R2: While `run_en` is low, `sram_addr` takes the value `start_addr` had at the previous clock edge.
- R3: If `run_en` is first sampled high at edge k, with `start_addr` steady at S since edge k-1, the stored word at S appears on the outputs after edge k+1. The next words follow on consecutive cycles, and no other word is presented first.
- R4: While `run_en` is high and `sram_addr` is below the top location (2^ADDR_W - 1), `sram_addr` increases by exactly one per clock.
- R5: While `run_en` is high and `sram_addr` is at the top location, the next `sram_addr` is the current `start_addr`, so the words at the top location and at the start address are presented on back-to-back cycles.
- R6: A change of `start_addr` while running does not disturb the ascending address sequence; the new value is first used at the next wrap.
- R7: For a presented pattern word W, `data_out` = W[15:0], `strobe_out` = W[16] and `txen_out` = W[17].
- R8: `src_sel` is sampled at the same edge as the word it applies to. Its encodings:
  - 2'b00 selects pattern memory.
  - 2'b01 selects zeros: `data_oe` high, `data_out` 0, strobe and transmit enable low.
  - 2'b10 and 2'b11 select high impedance: `data_oe` low, with all outputs driven to 0.
- R9: Once `run_en` has been low at two consecutive edges, `data_out` is 0 and `strobe_out` and `txen_out` are low, whatever `src_sel` selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock shared with SRAM and modulator |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Playback enable |
| src_sel | input | 2 | Sample bus source: 00 pattern, 01 zeros, 1x high impedance |
| start_addr | input | ADDR_W | First location of the looping pattern |
| sram_addr | output | ADDR_W | Read address to the synchronous SRAM |
| sram_rdata | input | 18 | Registered read data from the SRAM, one cycle after the address |
| data_out | output | 16 | Sample bus to the modulator |
| strobe_out | output | 1 | Data strobe to the modulator (word bit 16) |
| txen_out | output | 1 | Transmit enable to the modulator (word bit 17) |
| data_oe | output | 1 | Output enable shared by all 18 output bits |

## Verification
The assertions check the following on every cycle:
- the address walk: idle parking, unit steps and the wrap to the live start address;
- that high impedance drops the enable;
- that a stopped sequencer emits only zeros.

Only the bench's scenarios can show the rest, by pairing addresses with the data the SRAM returns:
- that the first word after enabling is the start word rather than a stale one;
- that the word fields land on the right pins;
- that the word at the top location is followed at once by the start word.

Random phases toggle the enable, selector and start address together. Directed phases cover starting at the top location, starting at zero, and moving the start address mid-pass.

// File: rtl/pattern_playback_pkg.sv
package pattern_playback_pkg;

    localparam int SAMPLE_W = 16;
    localparam int WORD_W   = SAMPLE_W + 2;

    typedef enum logic [1:0] {
        SRC_PATTERN = 2'b00,
        SRC_ZEROS   = 2'b01,
        SRC_FLOAT_A = 2'b10,
        SRC_FLOAT_B = 2'b11
    } bus_src_e;

    // Stored word layout: txen at the top, strobe below it, sample in the low bits.
    typedef struct packed {
        logic                txen;
        logic                strobe;
        logic [SAMPLE_W-1:0] sample;
    } pat_word_t;

    typedef struct packed {
        logic                oe;
        logic                txen;
        logic                strobe;
        logic [SAMPLE_W-1:0] sample;
    } bus_drive_t;

    function automatic logic src_drives_bus(input bus_src_e s);
        return (s == SRC_PATTERN) || (s == SRC_ZEROS);
    endfunction

    function automatic bus_drive_t idle_drive(input logic oe);
        bus_drive_t d;
        d        = '0;
        d.oe     = oe;
        return d;
    endfunction

endpackage

// File: rtl/pattern_playback_addr_gen.sv
module pattern_playback_addr_gen #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              word_valid
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_d;
    logic              at_top;
    logic              valid_q;

    assign at_top = (addr_q == TOP_ADDR);

    // Idle parks on the start location so the first read is already in flight.
    always_comb begin
        if (!run_en || at_top) begin
            addr_d = start_addr;
        end else begin
            addr_d = addr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            addr_q  <= addr_d;
            valid_q <= run_en;
        end
    end

    assign rd_addr    = addr_q;
    assign word_valid = valid_q;

endmodule

// File: rtl/pattern_playback_out_stage.sv
module pattern_playback_out_stage
    import pattern_playback_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] rd_word,
    input  logic [1:0]        src_sel,
    output bus_drive_t        drive
);
    bus_src_e   src;
    pat_word_t  word;
    bus_drive_t drive_d;
    bus_drive_t drive_q;

    assign src  = bus_src_e'(src_sel);
    assign word = pat_word_t'(rd_word);

    always_comb begin
        drive_d = idle_drive(src_drives_bus(src));
        if (word_valid && (src == SRC_PATTERN)) begin
            drive_d.sample = word.sample;
            drive_d.strobe = word.strobe;
            drive_d.txen   = word.txen;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drive_q <= '0;
        end else begin
            drive_q <= drive_d;
        end
    end

    assign drive = drive_q;

endmodule

// File: rtl/pattern_playback_seq.sv
module pattern_playback_seq
    import pattern_playback_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run_en,
    input  logic [1:0]          src_sel,
    input  logic [ADDR_W-1:0]   start_addr,
    output logic [ADDR_W-1:0]   sram_addr,
    input  logic [WORD_W-1:0]   sram_rdata,
    output logic [SAMPLE_W-1:0] data_out,
    output logic                strobe_out,
    output logic                txen_out,
    output logic                data_oe
);
    logic       word_valid;
    bus_drive_t drive;

    pattern_playback_addr_gen #(
        .ADDR_W(ADDR_W)
    ) i_addr_gen (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .start_addr(start_addr),
        .rd_addr   (sram_addr),
        .word_valid(word_valid)
    );

    pattern_playback_out_stage i_out_stage (
        .clk       (clk),
        .rst       (rst),
        .word_valid(word_valid),
        .rd_word   (sram_rdata),
        .src_sel   (src_sel),
        .drive     (drive)
    );

    assign data_out   = drive.sample;
    assign strobe_out = drive.strobe;
    assign txen_out   = drive.txen;
    assign data_oe    = drive.oe;

endmodule

// File: rtl/pattern_playback_seq_chk.sv
module pattern_playback_seq_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              run_en,
    input logic [1:0]        src_sel,
    input logic [ADDR_W-1:0] start_addr,
    input logic [ADDR_W-1:0] sram_addr,
    input logic [15:0]       data_out,
    input logic              strobe_out,
    input logic              txen_out,
    input logic              data_oe
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (sram_addr == '0) && (data_out == '0) && !strobe_out && !txen_out && !data_oe);

    p_idle_park_r2: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> sram_addr == $past(start_addr));

    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        (run_en && sram_addr != TOP_ADDR) |=> sram_addr == $past(sram_addr) + 1'b1);

    p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (run_en && sram_addr == TOP_ADDR) |=> sram_addr == $past(start_addr));

    p_float_r8: assert property (@(posedge clk) disable iff (rst)
        src_sel[1] |=> !data_oe && (data_out == '0) && !strobe_out && !txen_out);

    p_zero_src_r8: assert property (@(posedge clk) disable iff (rst)
        (src_sel == 2'b01) |=> data_oe && (data_out == '0) && !strobe_out && !txen_out);

    p_stopped_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!run_en ##1 !run_en) |=> (data_out == '0) && !strobe_out && !txen_out);

endmodule

bind pattern_playback_seq pattern_playback_seq_chk #(
    .ADDR_W(ADDR_W)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .run_en    (run_en),
    .src_sel   (src_sel),
    .start_addr(start_addr),
    .sram_addr (sram_addr),
    .data_out  (data_out),
    .strobe_out(strobe_out),
    .txen_out  (txen_out),
    .data_oe   (data_oe)
);

// File: tb/test_pattern_playback_seq.sv
`timescale 1ns/1ps
module test_pattern_playback_seq;

    localparam int AW = 6;
    localparam logic [AW-1:0] TOP = {AW{1'b1}};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          run_en = 1'b0;
    logic [1:0]    src_sel = 2'b00;
    logic [AW-1:0] start_addr = '0;
    logic [AW-1:0] sram_addr;
    logic [17:0]   sram_rdata = '0;
    logic [15:0]   data_out;
    logic          strobe_out;
    logic          txen_out;
    logic          data_oe;

    int n_checks = 0;
    int n_fail   = 0;
    string tag   = "R1";

    always #2 clk = ~clk;

    pattern_playback_seq #(.ADDR_W(AW)) i_pattern_playback_seq (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .src_sel   (src_sel),
        .start_addr(start_addr),
        .sram_addr (sram_addr),
        .sram_rdata(sram_rdata),
        .data_out  (data_out),
        .strobe_out(strobe_out),
        .txen_out  (txen_out),
        .data_oe   (data_oe)
    );

    function automatic logic [17:0] word_of(input logic [AW-1:0] a);
        logic [17:0] x;
        x = {12'h0, a} * 18'd40503 + 18'd1234;
        return x ^ ({12'h0, a} << 11) ^ ({12'h0, a} << 16);
    endfunction

    // SRAM stand-in: one cycle read latency
    always @(posedge clk) sram_rdata <= word_of(sram_addr);

    // Reference model built from the requirements
    logic [AW-1:0] m_addr = '0;
    logic [AW-1:0] m_rd   = '0;
    logic          m_val  = 1'b0;
    logic [15:0]   e_data = '0;
    logic          e_stb  = 1'b0;
    logic          e_txen = 1'b0;
    logic          e_oe   = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_addr <= '0; m_val <= 1'b0;
            e_data <= '0; e_stb <= 1'b0; e_txen <= 1'b0; e_oe <= 1'b0;
        end else begin
            logic [17:0] w;
            w = word_of(m_rd);
            e_oe <= !src_sel[1];
            if (m_val && src_sel == 2'b00) begin
                e_data <= w[15:0]; e_stb <= w[16]; e_txen <= w[17];
            end else begin
                e_data <= '0; e_stb <= 1'b0; e_txen <= 1'b0;
            end
            m_val  <= run_en;
            m_addr <= (!run_en || m_addr == TOP) ? start_addr : m_addr + 1'b1;
        end
        m_rd <= m_addr;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare_model();
        check(sram_addr == m_addr, tag, "sram_addr", 32'(sram_addr), 32'(m_addr));
        check({data_oe, txen_out, strobe_out, data_out} == {e_oe, e_txen, e_stb, e_data},
              tag, "outputs", {13'h0, data_oe, txen_out, strobe_out, data_out},
              {13'h0, e_oe, e_txen, e_stb, e_data});
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_model();
        end
    endtask

    logic done = 1'b0;

    initial begin
        logic [17:0] w;
        logic [AW-1:0] a_prev;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(sram_addr == '0 && data_out == '0 && !strobe_out && !txen_out && !data_oe,
              "R1", "reset state", {14'h0, data_oe, txen_out, strobe_out, data_out[12:0], sram_addr}, 32'h0);
        rst = 1'b0;

        // R2 idle parking
        tag = "R2"; start_addr = 6'd20;
        step(3);
        check(sram_addr == 6'd20, "R2", "idle address", 32'(sram_addr), 32'd20);

        // R3 first word is the start word
        tag = "R3"; run_en = 1'b1;
        step(2);
        w = word_of(6'd20);
        check(data_out == w[15:0], "R3", "first sample", 32'(data_out), 32'(w[15:0]));
        // R7 field mapping
        check(strobe_out == w[16] && txen_out == w[17], "R7", "side bits",
              {30'h0, txen_out, strobe_out}, {30'h0, w[17], w[16]});
        step(1);
        w = word_of(6'd21);
        check(data_out == w[15:0], "R3", "second sample", 32'(data_out), 32'(w[15:0]));

        // R4 / R6: change start mid pass
        tag = "R6";
        a_prev = sram_addr; start_addr = 6'd5;
        step(1);
        check(sram_addr == a_prev + 1'b1, "R6", "no jump on start change",
              32'(sram_addr), 32'(a_prev + 1'b1));
        tag = "R4";
        while (sram_addr != TOP) step(1);
        // R5 wrap to new start
        tag = "R5";
        step(1);
        check(sram_addr == 6'd5, "R5", "wrap target", 32'(sram_addr), 32'd5);
        step(1);
        w = word_of(TOP);
        check(data_out == w[15:0], "R5", "top word", 32'(data_out), 32'(w[15:0]));
        step(1);
        w = word_of(6'd5);
        check(data_out == w[15:0], "R5", "start word right after top", 32'(data_out), 32'(w[15:0]));

        // R8 source selection
        tag = "R8";
        src_sel = 2'b01; step(2);
        check(data_oe && data_out == '0, "R8", "zeros source", {15'h0, data_oe, data_out}, 32'h10000);
        src_sel = 2'b10; step(2);
        check(!data_oe, "R8", "float source enable", 32'(data_oe), 32'd0);
        src_sel = 2'b11; step(2);
        src_sel = 2'b00; step(3);

        // R9 stop
        tag = "R9"; run_en = 1'b0;
        step(3);
        check(data_out == '0 && !strobe_out && !txen_out, "R9", "stopped bus",
              {14'h0, txen_out, strobe_out, data_out}, 32'h0);

        // Corner: start at top location, and start at zero
        tag = "R5"; start_addr = TOP; step(1); run_en = 1'b1; step(8);
        check(sram_addr == TOP, "R5", "top-only loop", 32'(sram_addr), 32'(TOP));
        run_en = 1'b0; tag = "R4"; start_addr = '0; step(2); run_en = 1'b1; step(70);

        // Random mix
        tag = "R7";
        void'($urandom(32'd1357));
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 16) == 0) run_en = ~run_en;
            if (($urandom % 32) == 0) src_sel = 2'($urandom);
            if (($urandom % 24) == 0) start_addr = AW'($urandom);
            step(1);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule